// File: doc/BRIEF.md
# PC-Relative Capability Load Unit

This block executes one instruction form: a capability load whose address is formed relative to the program-counter capability. It decodes a 32-bit instruction word and builds the effective address from the program-counter capability's address plus a scaled, sign-extended literal, forced down to a 16-byte boundary. It then asks an external checker whether the program-counter capability authorises a 16-byte load at that address. Only after the checker approves does it issue a read to an external capability memory. The loaded 129-bit value has its tag cleared unless the authorising capability holds capability-load permission, and the result is written to the destination register.

A small state machine sequences the work: idle, check, read, writeback and fault. Every accepted instruction ends with a one-cycle `done` pulse. A faulting instruction raises `fault` with a cause code in that cycle and writes no register. A word that is not this instruction form, or a request made while capabilities are disabled, faults at once and issues no access.

Capability layout used by the block: bit 128 is the tag, bits [127:112] are permissions, and bits [63:0] are the address. Permission bit 2, which is capability bit 114, grants capability loads.

Top module: `pcl_capload`

## Requirements
- R1: A word is accepted as this instruction only when bits [31:22] equal 10'b1000001000. Any other word ends with `done` and `fault` one cycle after acceptance, with `fault_cause` = 3, no check request, no memory request and no register write.
- R2: The effective address is pcc[63:0] plus the 64-bit sign extension of {insn[21:5], 4'b0000}, with its low four bits then cleared (wrapping modulo 2^64). It is presented on both `chk_addr` and `mem_addr`.
- R3: When `cap_en` is low for a matching word, `done` and `fault` rise one cycle after acceptance with `fault_cause` = 1, and no check or memory request is made.
- R4: For a matching word with `cap_en` high, exactly one check request is made. It carries `chk_cap` equal to the accepted pcc, `chk_size` = 16 and `chk_perm` = 16'h0001 (bit 0 = load). `chk_req` is held until `chk_ack`. If `chk_ok` is low at the acknowledge, the instruction ends with `fault_cause` = 2 and no memory request.
- R5: A memory request is made only after an approved check, exactly once. `mem_req` and `mem_addr` are held until `mem_ack`.
- R6: The value written equals `mem_rdata` captured at `mem_ack`, except that bit 128 (the tag) is cleared when bit 114 of the authorising pcc is 0.
- R7: A successful instruction asserts `rf_we` for exactly one cycle, together with `done`. `rf_idx` equals insn[4:0] (0 to 31). A faulting instruction never asserts `rf_we`, and `fault_cause` is 0 when there is no fault.
- R8: `done` is a single-cycle pulse for each accepted instruction. `busy` is high from the cycle after acceptance through the `done` cycle. `start` is ignored while `busy` is high, including in the `done` cycle.
- R9: After reset the unit is idle, with `busy`, `done`, `fault`, `rf_we`, `chk_req` and `mem_req` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Present an instruction (taken when idle) |
| insn | input | 32 | Instruction word |
| pcc | input | 129 | Program-counter capability |
| cap_en | input | 1 | Capabilities enabled |
| busy | output | 1 | Instruction in progress |
| chk_req | output | 1 | Permission/bounds check request |
| chk_addr | output | 64 | Address to check |
| chk_size | output | 5 | Access size in bytes (16) |
| chk_perm | output | 16 | Requested permission mask (load) |
| chk_cap | output | 129 | Authorising capability |
| chk_ack | input | 1 | Check response valid |
| chk_ok | input | 1 | Check passed |
| mem_req | output | 1 | Capability memory read request |
| mem_addr | output | 64 | Read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 129 | Loaded capability |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 5 | Destination register index |
| rf_wdata | output | 129 | Value written |
| done | output | 1 | Instruction finished pulse |
| fault | output | 1 | Instruction faulted (with done) |
| fault_cause | output | 2 | 0 none, 1 disabled, 2 denied, 3 undefined |

## Verification
Two events can fall in the same cycle: the completion of an instruction (the `done` pulse from writeback or fault) and the arrival of a new `start`. The bench raises `start` for a valid, enabled word exactly in the sampled `done` cycle. It then judges at the ports that no check request follows and that `busy` stays low. A second coincidence is a checker or memory acknowledge in the very first cycle of its request. This is provoked with zero-delay responders and judged by the request count and the written value.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int INSN_W     = 32;
    localparam int CAP_W      = 129;
    localparam int ADDR_W     = 64;
    localparam int RIDX_W     = 5;
    localparam int IMM_W      = 17;
    localparam int IMM_LSB    = RIDX_W;
    localparam int OPC_W      = INSN_W - IMM_W - RIDX_W;
    localparam int OPC_LSB    = IMM_LSB + IMM_W;
    localparam int ACC_BYTES  = 16;
    localparam int SCALE_SH   = $clog2(ACC_BYTES);
    localparam int SIZE_W     = $clog2(ACC_BYTES) + 1;
    localparam int TAG_BIT    = CAP_W - 1;
    localparam int PERM_W     = 16;
    localparam int PERM_LSB   = 112;
    localparam int PERM_LOAD_IDX    = 0;
    localparam int PERM_LOADCAP_IDX = 2;
    localparam int LOADCAP_BIT      = PERM_LSB + PERM_LOADCAP_IDX;

    localparam logic [OPC_W-1:0] OPC_LDCAP_PCREL = 10'b1000001000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WB,
        ST_FAULT
    } state_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'd0,
        FC_DISABLED = 2'd1,
        FC_DENIED   = 2'd2,
        FC_UNDEF    = 2'd3
    } fcause_e;

    typedef struct packed {
        logic              hit;
        logic [RIDX_W-1:0] rd;
        logic [ADDR_W-1:0] ea;
    } dec_t;

    function automatic logic [ADDR_W-1:0] scaled_offset(input logic [IMM_W-1:0] imm);
        logic [IMM_W+SCALE_SH-1:0] raw;
        raw = {imm, {SCALE_SH{1'b0}}};
        return {{(ADDR_W-IMM_W-SCALE_SH){imm[IMM_W-1]}}, raw};
    endfunction

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:SCALE_SH], {SCALE_SH{1'b0}}};
    endfunction

    function automatic logic [PERM_W-1:0] load_perm_mask();
        logic [PERM_W-1:0] m;
        m = '0;
        m[PERM_LOAD_IDX] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pcl_decode.sv
module pcl_decode
    import pcl_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [ADDR_W-1:0] base_addr,
    output dec_t              dec
);
    logic [OPC_W-1:0]  opc;
    logic [IMM_W-1:0]  imm;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        opc     = insn[OPC_LSB +: OPC_W];
        imm     = insn[IMM_LSB +: IMM_W];
        sum     = base_addr + scaled_offset(imm);
        dec.hit = (opc == OPC_LDCAP_PCREL);
        dec.rd  = insn[RIDX_W-1:0];
        dec.ea  = align_down(sum);
    end
endmodule

// File: rtl/pcl_squash.sv
module pcl_squash
    import pcl_pkg::*;
#(
    parameter bit SQUASH_ON = 1'b1
) (
    input  logic [CAP_W-1:0] loaded,
    input  logic             auth_loadcap,
    output logic [CAP_W-1:0] result
);
    generate
        if (SQUASH_ON) begin : g_squash
            always_comb begin
                result          = loaded;
                result[TAG_BIT] = loaded[TAG_BIT] & auth_loadcap;
            end
        end else begin : g_pass
            logic unused_auth;
            assign unused_auth = auth_loadcap;
            assign result = loaded;
        end
    endgenerate
endmodule

// File: rtl/pcl_ctrl.sv
module pcl_ctrl
    import pcl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    dec_hit,
    input  logic    cap_en,
    input  logic    chk_ack,
    input  logic    chk_ok,
    input  logic    mem_ack,
    output state_e  state,
    output fcause_e cause,
    output logic    accept
);
    state_e  state_d;
    fcause_e cause_q, cause_d;

    assign accept = start && (state == ST_IDLE);

    always_comb begin
        state_d = state;
        cause_d = cause_q;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!dec_hit) begin
                        state_d = ST_FAULT;
                        cause_d = FC_UNDEF;
                    end else if (!cap_en) begin
                        state_d = ST_FAULT;
                        cause_d = FC_DISABLED;
                    end else begin
                        state_d = ST_CHECK;
                        cause_d = FC_NONE;
                    end
                end
            end
            ST_CHECK: begin
                if (chk_ack) begin
                    if (chk_ok) begin
                        state_d = ST_READ;
                    end else begin
                        state_d = ST_FAULT;
                        cause_d = FC_DENIED;
                    end
                end
            end
            ST_READ:  if (mem_ack) state_d = ST_WB;
            ST_WB:    state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cause_q <= FC_NONE;
        end else begin
            state   <= state_d;
            cause_q <= cause_d;
        end
    end

    assign cause = (state == ST_FAULT) ? cause_q : FC_NONE;
endmodule

// File: rtl/pcl_capload.sv
module pcl_capload
    import pcl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [INSN_W-1:0]    insn,
    input  logic [CAP_W-1:0]     pcc,
    input  logic                 cap_en,
    output logic                 busy,
    output logic                 chk_req,
    output logic [ADDR_W-1:0]    chk_addr,
    output logic [SIZE_W-1:0]    chk_size,
    output logic [PERM_W-1:0]    chk_perm,
    output logic [CAP_W-1:0]     chk_cap,
    input  logic                 chk_ack,
    input  logic                 chk_ok,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [CAP_W-1:0]     mem_rdata,
    output logic                 rf_we,
    output logic [RIDX_W-1:0]    rf_idx,
    output logic [CAP_W-1:0]     rf_wdata,
    output logic                 done,
    output logic                 fault,
    output logic [1:0]           fault_cause
);
    dec_t             dec;
    state_e           state;
    fcause_e          cause;
    logic             accept;
    logic [CAP_W-1:0] pcc_q;
    logic [ADDR_W-1:0] ea_q;
    logic [RIDX_W-1:0] rd_q;
    logic [CAP_W-1:0] data_q;
    logic [CAP_W-1:0] squashed;

    pcl_decode u_dec (
        .insn      (insn),
        .base_addr (pcc[ADDR_W-1:0]),
        .dec       (dec)
    );

    pcl_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .dec_hit (dec.hit),
        .cap_en  (cap_en),
        .chk_ack (chk_ack),
        .chk_ok  (chk_ok),
        .mem_ack (mem_ack),
        .state   (state),
        .cause   (cause),
        .accept  (accept)
    );

    pcl_squash #(.SQUASH_ON(1'b1)) u_sq (
        .loaded       (mem_rdata),
        .auth_loadcap (pcc_q[LOADCAP_BIT]),
        .result       (squashed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pcc_q  <= '0;
            ea_q   <= '0;
            rd_q   <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                pcc_q <= pcc;
                ea_q  <= dec.ea;
                rd_q  <= dec.rd;
            end
            if (state == ST_READ && mem_ack) begin
                data_q <= squashed;
            end
        end
    end

    assign busy        = (state != ST_IDLE);
    assign chk_req     = (state == ST_CHECK);
    assign chk_addr    = ea_q;
    assign chk_size    = SIZE_W'(ACC_BYTES);
    assign chk_perm    = load_perm_mask();
    assign chk_cap     = pcc_q;
    assign mem_req     = (state == ST_READ);
    assign mem_addr    = ea_q;
    assign rf_we       = (state == ST_WB);
    assign rf_idx      = rd_q;
    assign rf_wdata    = data_q;
    assign done        = (state == ST_WB) || (state == ST_FAULT);
    assign fault       = (state == ST_FAULT);
    assign fault_cause = cause;
endmodule

// File: rtl/pcl_capload_chk.sv
module pcl_capload_chk
    import pcl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [INSN_W-1:0] insn,
    input logic              cap_en,
    input logic              busy,
    input logic              chk_req,
    input logic              chk_ack,
    input logic              chk_ok,
    input logic [ADDR_W-1:0] chk_addr,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_we,
    input logic              done,
    input logic              fault,
    input logic [1:0]        fault_cause
);
    // R1
    a_r1_undef_fault: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && insn[OPC_LSB +: OPC_W] != OPC_LDCAP_PCREL)
        |=> (fault && done && fault_cause == 2'd3));

    // R3
    a_r3_disabled_fault: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && insn[OPC_LSB +: OPC_W] == OPC_LDCAP_PCREL && !cap_en)
        |=> (fault && fault_cause == 2'd1 && !chk_req && !mem_req));

    // R4
    a_r4_chk_hold: assert property (@(posedge clk) disable iff (rst)
        (chk_req && !chk_ack) |=> (chk_req && $stable(chk_addr)));

    // R4
    a_r4_denied_fault: assert property (@(posedge clk) disable iff (rst)
        (chk_req && chk_ack && !chk_ok) |=> (fault && fault_cause == 2'd2 && !mem_req));

    // R5
    a_r5_read_after_ok: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(chk_req && chk_ack && chk_ok));

    // R5
    a_r5_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R7
    a_r7_no_write_on_fault: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && fault));

    // R7
    a_r7_write_with_done: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (done && fault_cause == 2'd0));

    // R8
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    // R8
    a_r8_one_request: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chk_req, mem_req, done}));
endmodule

bind pcl_capload pcl_capload_chk u_chk (.*);

// File: tb/pcl_capload_tb.sv
module pcl_capload_tb;
    import pcl_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [31:0]       insn = '0;
    logic [128:0]      pcc = '0;
    logic              cap_en = 1'b0;
    logic              busy, chk_req, mem_req, rf_we, done, fault;
    logic [63:0]       chk_addr, mem_addr;
    logic [4:0]        chk_size, rf_idx;
    logic [15:0]       chk_perm;
    logic [128:0]      chk_cap, rf_wdata;
    logic              chk_ack = 1'b0, chk_ok = 1'b0, mem_ack = 1'b0;
    logic [128:0]      mem_rdata = '0;
    logic [1:0]        fault_cause;

    always #2 clk = ~clk;

    pcl_capload u_dut (
        .clk(clk), .rst(rst), .start(start), .insn(insn), .pcc(pcc), .cap_en(cap_en),
        .busy(busy), .chk_req(chk_req), .chk_addr(chk_addr), .chk_size(chk_size),
        .chk_perm(chk_perm), .chk_cap(chk_cap), .chk_ack(chk_ack), .chk_ok(chk_ok),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata), .done(done),
        .fault(fault), .fault_cause(fault_cause)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // responder controls
    int           chk_delay = 0, mem_delay = 0, ccnt = 0, mcnt = 0;
    bit           ok_val = 1;
    logic [128:0] mem_val = '0;
    bit           chk_prev = 0, mem_prev = 0;
    int           n_chk = 0, n_mem = 0, n_we = 0;
    logic [63:0]  got_chk_addr, got_mem_addr;
    logic [128:0] got_chk_cap;
    logic [4:0]   got_size;
    logic [15:0]  got_perm;

    always @(negedge clk) begin
        if (chk_req) begin
            if (!chk_prev) begin
                n_chk++; ccnt = 0;
                got_chk_addr = chk_addr; got_chk_cap = chk_cap;
                got_size = chk_size; got_perm = chk_perm;
            end
            chk_ack = (ccnt >= chk_delay);
            chk_ok  = ok_val;
            ccnt++;
        end else begin
            chk_ack = 1'b0; chk_ok = 1'b0;
        end
        chk_prev = chk_req;
        if (mem_req) begin
            if (!mem_prev) begin
                n_mem++; mcnt = 0; got_mem_addr = mem_addr;
            end
            mem_ack   = (mcnt >= mem_delay);
            mem_rdata = mem_ack ? mem_val : ~mem_val;
            mcnt++;
        end else begin
            mem_ack = 1'b0; mem_rdata = '0;
        end
        mem_prev = mem_req;
        if (rf_we) n_we++;
    end

    task automatic check(input bit cond, input string tag, input logic [128:0] act, input logic [128:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_ea(input logic [63:0] base, input logic [16:0] imm);
        logic [63:0] off;
        off = {{43{imm[16]}}, imm, 4'b0000};
        return (base + off) & ~64'hF;
    endfunction

    function automatic logic [31:0] mk_insn(input logic [16:0] imm, input logic [4:0] rd);
        return {10'b1000001000, imm, rd};
    endfunction

    task automatic run(input logic [31:0] w, input logic [128:0] cap, input bit en,
                       input bit ok, input int cd, input int md,
                       input logic [128:0] data, input bit poke_done);
        bit hit;
        int cyc;
        logic [1:0] ecause;
        logic [128:0] ewdata;
        logic [63:0] eaddr;
        hit = (w[31:22] == 10'b1000001000);
        ecause = !hit ? 2'd3 : (!en ? 2'd1 : (!ok ? 2'd2 : 2'd0));
        eaddr = exp_ea(cap[63:0], w[21:5]);
        ewdata = data;
        ewdata[128] = data[128] & cap[114];
        chk_delay = cd; mem_delay = md; ok_val = ok; mem_val = data;
        n_chk = 0; n_mem = 0; n_we = 0;
        insn = w; pcc = cap; cap_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        insn = $urandom; pcc = {$urandom, $urandom, $urandom, $urandom, $urandom};
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check(done === 1'b1, "R8 done seen", {128'b0, done}, 129'd1);
        if (ecause == 2'd1 || ecause == 2'd3)
            check(cyc == 0, "R1/R3 fault latency", cyc, 0);
        check(fault === (ecause != 2'd0), "R7 fault flag", {128'b0, fault}, {128'b0, ecause != 2'd0});
        check(fault_cause === ecause, "R1 R3 R4 R7 cause", {127'b0, fault_cause}, {127'b0, ecause});
        check(rf_we === (ecause == 2'd0), "R7 write enable", {128'b0, rf_we}, {128'b0, ecause == 2'd0});
        if (ecause == 2'd0) begin
            check(rf_idx === w[4:0], "R7 index", {124'b0, rf_idx}, {124'b0, w[4:0]});
            check(rf_wdata === ewdata, "R6 written value", rf_wdata, ewdata);
        end
        if (poke_done) begin
            insn = mk_insn(17'h00010, 5'd3); cap_en = 1'b1; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b0 && busy === 1'b0, "R8 pulse/idle", {127'b0, done, busy}, 129'd0);
        if (poke_done) begin
            repeat (3) @(negedge clk);
            check(busy === 1'b0 && n_chk == ((hit && en) ? 1 : 0), "R8 start in done cycle ignored",
                  n_chk, (hit && en) ? 1 : 0);
        end
        check(n_chk == ((hit && en) ? 1 : 0), "R1 R3 R4 check count", n_chk, (hit && en) ? 1 : 0);
        check(n_mem == ((ecause == 2'd0) ? 1 : 0), "R4 R5 mem count", n_mem, (ecause == 2'd0) ? 1 : 0);
        check(n_we == ((ecause == 2'd0) ? 1 : 0), "R7 write count", n_we, (ecause == 2'd0) ? 1 : 0);
        if (hit && en) begin
            check(got_chk_addr === eaddr, "R2 check address", got_chk_addr, eaddr);
            check(got_chk_cap === cap, "R4 authorising cap", got_chk_cap, cap);
            check(got_size === 5'd16 && got_perm === 16'h0001, "R4 size/perm",
                  {108'b0, got_size, got_perm}, {108'b0, 5'd16, 16'h0001});
        end
        if (ecause == 2'd0)
            check(got_mem_addr === eaddr, "R2 R5 mem address", got_mem_addr, eaddr);
    endtask

    function automatic logic [128:0] rcap();
        return {$urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [128:0] c;
        void'($urandom(32'h5eed1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check({busy, done, fault, rf_we, chk_req, mem_req} === 6'b0, "R9 reset idle",
              {123'b0, busy, done, fault, rf_we, chk_req, mem_req}, 129'd0);
        // directed: extreme immediates, wrap, zero-latency
        c = rcap(); c[114] = 1'b1; c[63:0] = 64'h0000_0000_0001_0007;
        run(mk_insn(17'h0FFFF, 5'd0), c, 1, 1, 0, 0, {1'b1, 128'hA5A5}, 0);
        c[63:0] = 64'h0000_0000_0001_000F;
        run(mk_insn(17'h10000, 5'd31), c, 1, 1, 2, 3, {1'b1, 128'h1234}, 0);
        c[63:0] = 64'hFFFF_FFFF_FFFF_FFF7;
        run(mk_insn(17'h00003, 5'd7), c, 1, 1, 1, 0, {1'b1, 128'hBEEF}, 0);
        run(mk_insn(17'h1FFFF, 5'd9), c, 1, 1, 0, 1, {1'b0, 128'h77}, 0);
        // R6 tag squash with no load-cap permission
        c[114] = 1'b0;
        run(mk_insn(17'h00020, 5'd12), c, 1, 1, 0, 0, {1'b1, 128'hCAFE}, 1);
        // R3 disabled, R4 denied, R1 undefined
        run(mk_insn(17'h00001, 5'd1), c, 0, 1, 0, 0, '0, 1);
        run(mk_insn(17'h00001, 5'd1), c, 1, 0, 4, 0, '0, 1);
        run(32'h8210_0000 ^ 32'h0040_0000, c, 1, 1, 0, 0, '0, 1);
        run(32'h0000_0000, c, 0, 1, 0, 0, '0, 0);
        // constrained random
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            w = mk_insn(17'($urandom), 5'($urandom));
            if ($urandom_range(0, 9) == 0) w[31:22] = 10'($urandom);
            run(w, rcap(), ($urandom_range(0, 7) != 0), ($urandom_range(0, 4) != 0),
                $urandom_range(0, 3), $urandom_range(0, 3), rcap(), ($urandom_range(0, 5) == 0));
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule